// File: doc/BRIEF.md
# Flash Region Access Protection Gate

This block sits between a CPU bus and an on-chip flash array and decides, access by access, whether the flash may be touched. Protection is on only when two bits are both 1. The first is a one-time-programmable enable held outside the block and presented on `otp_en`. The second is a run-time activation bit held inside the block. While protection is on, the flash window is sealed to every instruction that was not itself fetched from flash. A sealed read does not fault. It returns a fixed substitute word one cycle later. A sealed write never reaches the array.

The activation bit is write-only. It is reached by a write to any even address inside the flash window, but only when the issuing instruction was fetched from flash. Reset sets it to 1, so a part whose one-time enable is programmed always leaves reset protected. Its current value can be seen only through the erase/program inhibit output, which is high exactly while protection is on.

Reads are tracked by a three-state response machine. `RSP_IDLE` moves to `RSP_PASS` on an allowed window read and to `RSP_DUMMY` on a blocked window read. From any state, a cycle without a window read returns the machine to `RSP_IDLE`. In `RSP_PASS` the array data is forwarded. In `RSP_DUMMY` the substitute word is driven.

Top module: `flash_guard`

## Requirements
- R1: After reset the activation bit is 1: `pgm_inhibit` equals `otp_en`, and `rd_valid` is 0.
- R2: `pgm_inhibit` is 1 exactly when `otp_en` is 1 and the activation bit is 1.
- R3: A write to an even address inside the window, issued with `req_from_flash`=1, loads bit `ACT_BIT` (default 0) of `req_wdata` into the activation bit. The new value is visible on `pgm_inhibit` in the cycle after the write.
- R4: A write with `req_from_flash`=0 never changes the activation bit, whatever its address or data.
- R5: A write to an odd address inside the window never changes the activation bit.
- R6: While protection is on, a window read with `req_from_flash`=0 gives `rd_valid`=1 and `rd_data`=`DUMMY_WORD` (default 16'h7887) in the next cycle.
- R7: While protection is on, a window write with `req_from_flash`=0 leaves `arr_we` at 0 and `arr_wdata` at 0.
- R8: A window access with `req_from_flash`=1 always passes. A write drives `arr_we`=1 in the same cycle. A read gives `rd_valid`=1 and `rd_data`=`arr_rdata` in the next cycle.
- R9: While protection is off, window accesses with `req_from_flash`=0 pass exactly as in R8.
- R10: Accesses outside the window (`WIN_BASE`..`WIN_BASE+WIN_SIZE-1`, default 16'h4000..16'h7FFF) never raise `arr_we` and never produce `rd_valid` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| otp_en | input | 1 | One-time-programmable protection enable |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | AW (16) | Byte address of the access |
| req_write | input | 1 | 1 = write, 0 = read or fetch |
| req_wdata | input | DW (16) | Write data |
| req_from_flash | input | 1 | Requesting instruction was fetched from flash |
| arr_rdata | input | DW (16) | Read data from the flash array, valid in the cycle after the request |
| arr_we | output | 1 | Write strobe to the array |
| arr_wdata | output | DW (16) | Write data to the array, zero unless `arr_we` |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | DW (16) | Read response data |
| pgm_inhibit | output | 1 | Erase/program inhibit (protection on) |

## Verification
On every cycle, the assertions check four things. A substituted read follows every blocked read. The array write strobe never rises for a sealed write. Writes from outside flash never move the inhibit. A write from flash to an even address leaves the inhibit equal to the enable ANDed with the written bit. They also tie every read response to a window read in the cycle before. Only the bench scenarios can show that reset restores protection after the bit was cleared, that a cleared bit opens the window to outside code, and that odd-address writes leave the bit alone.

// File: rtl/fg_pkg.sv
package fg_pkg;

    // Read response state: which source drives rd_data in the cycle after a read
    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_PASS  = 2'd1,
        RSP_DUMMY = 2'd2
    } rsp_state_e;

    // Classification of the current request
    typedef struct packed {
        logic in_win;
        logic even;
        logic rd;
        logic wr;
    } acc_class_t;

endpackage

// File: rtl/fg_decode.sv
module fg_decode
    import fg_pkg::*;
#(
    parameter int AW       = 16,
    parameter int WIN_BASE = 'h4000,
    parameter int WIN_SIZE = 'h4000
) (
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    output acc_class_t    cls
);
    localparam logic [AW:0] LO = (AW+1)'(WIN_BASE);
    localparam logic [AW:0] HI = (AW+1)'(WIN_BASE + WIN_SIZE);

    logic [AW:0] addr_x;

    always_comb begin
        addr_x     = {1'b0, req_addr};
        cls.in_win = (addr_x >= LO) && (addr_x < HI);
        cls.even   = ~req_addr[0];
        cls.rd     = req_valid && !req_write && cls.in_win;
        cls.wr     = req_valid &&  req_write && cls.in_win;
    end
endmodule

// File: rtl/fg_act_reg.sv
module fg_act_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_val,
    output logic act
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            act <= 1'b1;
        else if (load)
            act <= load_val;
    end
endmodule

// File: rtl/fg_resp_fsm.sv
module fg_resp_fsm
    import fg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic blocked,
    output logic rsp_valid,
    output logic rsp_dummy
);
    rsp_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= RSP_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        if (!rd_req)
            nxt = RSP_IDLE;
        else if (blocked)
            nxt = RSP_DUMMY;
        else
            nxt = RSP_PASS;
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_dummy = 1'b0;
        unique case (state)
            RSP_IDLE:  ;
            RSP_PASS:  rsp_valid = 1'b1;
            RSP_DUMMY: begin
                rsp_valid = 1'b1;
                rsp_dummy = 1'b1;
            end
            default:   ;
        endcase
    end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import fg_pkg::*;
#(
    parameter int          AW         = 16,
    parameter int          DW         = 16,
    parameter int          WIN_BASE   = 'h4000,
    parameter int          WIN_SIZE   = 'h4000,
    parameter int          ACT_BIT    = 0,
    parameter logic [15:0] DUMMY_WORD = 16'h7887
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          otp_en,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    input  logic [DW-1:0] req_wdata,
    input  logic          req_from_flash,
    input  logic [DW-1:0] arr_rdata,
    output logic          arr_we,
    output logic [DW-1:0] arr_wdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          pgm_inhibit
);
    localparam logic [DW-1:0] DUMMY_X = DW'(DUMMY_WORD);

    acc_class_t cls;
    logic       act;
    logic       prot_on;
    logic       sealed;
    logic       ctl_load;
    logic       rsp_valid;
    logic       rsp_dummy;

    fg_decode #(.AW(AW), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .cls       (cls)
    );

    // Control register: any even window address, only from flash-resident code
    assign ctl_load = cls.wr && cls.even && req_from_flash;

    fg_act_reg u_act (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctl_load),
        .load_val (req_wdata[ACT_BIT]),
        .act      (act)
    );

    assign prot_on = otp_en && act;
    assign sealed  = prot_on && !req_from_flash;

    fg_resp_fsm u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (cls.rd),
        .blocked   (sealed),
        .rsp_valid (rsp_valid),
        .rsp_dummy (rsp_dummy)
    );

    always_comb begin
        arr_we      = cls.wr && !sealed;
        arr_wdata   = arr_we ? req_wdata : '0;
        rd_valid    = rsp_valid;
        rd_data     = !rsp_valid ? '0 : (rsp_dummy ? DUMMY_X : arr_rdata);
        pgm_inhibit = prot_on;
    end
endmodule

// File: rtl/fg_guard_chk.sv
module fg_guard_chk #(
    parameter int          AW         = 16,
    parameter int          DW         = 16,
    parameter int          WIN_BASE   = 'h4000,
    parameter int          WIN_SIZE   = 'h4000,
    parameter logic [15:0] DUMMY_WORD = 16'h7887
) (
    input logic          clk,
    input logic          rst_n,
    input logic          otp_en,
    input logic          req_valid,
    input logic [AW-1:0] req_addr,
    input logic          req_write,
    input logic          act_wbit,
    input logic          req_from_flash,
    input logic          arr_we,
    input logic          rd_valid,
    input logic [DW-1:0] rd_data,
    input logic          pgm_inhibit
);
    localparam logic [AW:0] LO = (AW+1)'(WIN_BASE);
    localparam logic [AW:0] HI = (AW+1)'(WIN_BASE + WIN_SIZE);

    logic in_win;
    assign in_win = ({1'b0, req_addr} >= LO) && ({1'b0, req_addr} < HI);

    // R6
    blocked_read_dummy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && in_win && !req_from_flash && pgm_inhibit)
        |=> (rd_valid && rd_data == DW'(DUMMY_WORD)));

    // R7
    sealed_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (req_from_flash || !pgm_inhibit));

    // R4
    outside_write_keeps_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_from_flash && $stable(otp_en))
        |=> (pgm_inhibit == $past(pgm_inhibit) || otp_en != $past(otp_en)));

    // R3
    inside_write_loads_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && in_win && !req_addr[0] && req_from_flash)
        |=> (pgm_inhibit == (otp_en && $past(act_wbit))));

    // R10
    response_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write && in_win));
endmodule

bind flash_guard fg_guard_chk #(
    .AW(AW), .DW(DW), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE), .DUMMY_WORD(DUMMY_WORD)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .otp_en         (otp_en),
    .req_valid      (req_valid),
    .req_addr       (req_addr),
    .req_write      (req_write),
    .act_wbit       (req_wdata[ACT_BIT]),
    .req_from_flash (req_from_flash),
    .arr_we         (arr_we),
    .rd_valid       (rd_valid),
    .rd_data        (rd_data),
    .pgm_inhibit    (pgm_inhibit)
);

// File: tb/sim_flash_guard.sv
module sim_flash_guard;
    localparam logic [15:0] DUMMY = 16'h7887;
    localparam logic [15:0] ARRD  = 16'h5AC3;

    typedef struct packed {
        logic        otp;
        logic [15:0] addr;
        logic        wr;
        logic [15:0] wdata;
        logic        ff;
        logic        exp_we;
        logic        exp_rv;
        logic [15:0] exp_rd;
        logic        exp_inh;
    } vec_t;

    // Protection bit stays 1 through this table
    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 16'h4010, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, DUMMY,    1'b1}, // R6
        '{1'b1, 16'h4020, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, ARRD,     1'b1}, // R8 read
        '{1'b1, 16'h4031, 1'b1, 16'h1234, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1}, // R7
        '{1'b1, 16'h4031, 1'b1, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b1}, // R8 write, R5
        '{1'b0, 16'h4010, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, ARRD,     1'b0}, // R9 read, R2
        '{1'b0, 16'h4011, 1'b1, 16'h00FF, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0}, // R9 write
        '{1'b1, 16'h2000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1}, // R10 read
        '{1'b1, 16'h8000, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1}, // R10 write
        '{1'b1, 16'h7FFE, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, DUMMY,    1'b1}, // R6 top edge
        '{1'b1, 16'h4000, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1}  // R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        otp_en = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        req_from_flash = 1'b0;
    logic [15:0] arr_rdata = ARRD;
    logic        arr_we;
    logic [15:0] arr_wdata;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        pgm_inhibit;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    flash_guard u0 (
        .clk(clk), .rst_n(rst_n), .otp_en(otp_en), .req_valid(req_valid),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .req_from_flash(req_from_flash), .arr_rdata(arr_rdata), .arr_we(arr_we),
        .arr_wdata(arr_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .pgm_inhibit(pgm_inhibit)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one request; returns same-cycle write strobe and next-cycle response
    task automatic access(input logic otp, input logic [15:0] a, input logic w,
                          input logic [15:0] d, input logic ff,
                          output logic we, output logic rv, output logic [15:0] rd,
                          output logic inh);
        @(negedge clk);
        otp_en = otp; req_valid = 1'b1; req_addr = a;
        req_write = w; req_wdata = d; req_from_flash = ff;
        #1 we = arr_we;
        @(posedge clk);
        #1;
        rv = rd_valid; rd = rd_data; inh = pgm_inhibit;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic we, rv, inh;
        logic [15:0] rd;

        repeat (3) @(posedge clk);
        #1 check("R1 inhibit at reset", 16'(pgm_inhibit), 16'h1);
        @(negedge clk) rst_n = 1'b1;
        #1 check("R1 rd_valid after reset", 16'(rd_valid), 16'h0);
        check("R1 inhibit after reset", 16'(pgm_inhibit), 16'h1);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i].otp, VEC[i].addr, VEC[i].wr, VEC[i].wdata, VEC[i].ff, we, rv, rd, inh);
            check($sformatf("R7/R8/R9/R10 vec%0d arr_we", i), 16'(we), 16'(VEC[i].exp_we));
            check($sformatf("R6/R8/R9/R10 vec%0d rd_valid", i), 16'(rv), 16'(VEC[i].exp_rv));
            if (VEC[i].exp_rv)
                check($sformatf("R6/R8/R9 vec%0d rd_data", i), rd, VEC[i].exp_rd);
            check($sformatf("R2/R4/R5 vec%0d inhibit", i), 16'(inh), 16'(VEC[i].exp_inh));
        end

        // R3: clear from flash-resident code
        access(1'b1, 16'h4002, 1'b1, 16'hFFFE, 1'b1, we, rv, rd, inh);
        check("R3 clear from flash", 16'(inh), 16'h0);
        // R9: window now open to outside code
        access(1'b1, 16'h4010, 1'b0, 16'h0000, 1'b0, we, rv, rd, inh);
        check("R9 outside read when cleared", rd, ARRD);
        // R4: outside write cannot set the bit again
        access(1'b1, 16'h4004, 1'b1, 16'h0001, 1'b0, we, rv, rd, inh);
        check("R4 outside set ignored", 16'(inh), 16'h0);
        check("R9 outside write passes when cleared", 16'(we), 16'h1);
        // R3: set again from flash
        access(1'b1, 16'h4006, 1'b1, 16'h0001, 1'b1, we, rv, rd, inh);
        check("R3 set from flash", 16'(inh), 16'h1);
        // R5: odd-address write from flash leaves bit alone
        access(1'b1, 16'h4007, 1'b1, 16'h0000, 1'b1, we, rv, rd, inh);
        check("R5 odd write keeps bit", 16'(inh), 16'h1);
        // R1: reset restores protection after clear
        access(1'b1, 16'h5000, 1'b1, 16'h0000, 1'b1, we, rv, rd, inh);
        check("R3 clear before reset", 16'(inh), 16'h0);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        #1 check("R1 reset re-arms", 16'(pgm_inhibit), 16'h1);
        access(1'b1, 16'h6000, 1'b0, 16'h0000, 1'b0, we, rv, rd, inh);
        check("R6 dummy after re-arm", rd, DUMMY);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule